// File: doc/BRIEF.md
# I2C 16-bit Port Expander

This block is a slave on a two-wire serial bus that gives a host access to a 16-bit general-purpose port. The port is handled as two 8-bit halves. Serial clock and data arrive as samples in the system clock domain. The block resynchronises them and finds their edges. It detects bus start and stop conditions. It matches a 7-bit device address whose upper four bits are fixed and whose lower three bits come from strap pins. When the address matches, it acknowledges by pulling the data line low.

No register pointer exists. The first data byte of a transfer always targets the low half, and later bytes alternate between the two halves. On a write, each received byte is loaded into the output latch of the current half. On a read, the block returns the input port halves in the same alternating order for as long as the host keeps acknowledging.

Each completed half access produces a one-cycle strobe. A separate interrupt block can use these strobes to clear its pending state. The data line is open-drain: the block only ever asks for it to be pulled low.

Top module: `i2c_port_expander`

## Requirements
- R1: A START (data falling while clock is high) restarts address reception. A STOP (data rising while clock is high) returns the block to idle with the data line released. Bytes clocked without a preceding START are not acknowledged.
- R2: The address byte is received MSB first. Its bits 7..4 must equal 4'b0100 and its bits 3..1 must equal the strap pins. Bit 0 is the direction, with 1 meaning read. On a match, the block pulls data low during the ninth clock.
- R3: After an address mismatch, the block does not acknowledge, never pulls data low, and changes no output until the next START.
- R4: In a write, the first data byte loads port_out_o[7:0] and the next loads port_out_o[15:8]. Later bytes keep alternating. Each load happens at that byte's acknowledge.
- R5: In a read, the bytes returned are port_in_i[7:0], then port_in_i[15:8], alternating, MSB first. Each byte is captured on the clock falling edge that starts it, so later input changes within the byte have no effect.
- R6: A read continues while the host acknowledges. After a host no-acknowledge, the block releases data and drives nothing until the next START.
- R7: Every read byte raises a one-cycle pulse on rd_strobe_o bit h, where h is the half that was read (0 = low half, 1 = high half). The pulse comes at the end of the byte's eighth bit.
- R8: The data pull-down changes only while the clock is low, in response to a clock falling edge.
- R9: A repeated START at any bit position of a transfer abandons it and begins a new address phase.
- R10: While reset is high, and straight after it, port_out_o is all ones, sda_pull_o is 0, and both strobe outputs are 0.
- R11: A STOP in the middle of a data byte discards the partial byte. The latches keep the values loaded at the last acknowledge.
- R12: Each write byte raises a one-cycle pulse on wr_strobe_o bit h for the half loaded. No more than one bit of either strobe output is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock sample |
| sda_i | input | 1 | Serial data sample (wired bus level) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Low three address bits |
| port_in_i | input | 16 | Input port, low half in bits 7..0 |
| port_out_o | output | 16 | Output latch, low half in bits 7..0 |
| rd_strobe_o | output | 2 | Per-half read completion pulse |
| wr_strobe_o | output | 2 | Per-half write completion pulse |

## Verification
Most internal faults appear on the port pins within a single byte. A wrong bit counter or a shift-register slip shows up at the ninth clock: the acknowledge is missing, returned data is rotated, or a latch gets a shifted value. A wrong half index puts the write into the wrong half of port_out_o, or sends the wrong port byte on the first read. It also shows as a strobe on the wrong bit, and these strobes are counted per half over the whole run. A state machine stuck in a driving state keeps sda_pull_o high after a no-acknowledge or a STOP. This is caught at the next clock bit, and the bench samples the released bus level there.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_ACK_R
  } link_state_t;
endpackage

// File: rtl/pex_bus_sampler.sv
module pex_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_evt,
  output logic stop_evt
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[TOP];
      sda_q    <= sda_sync[TOP];
    end
  end

  assign scl_lvl   = scl_sync[TOP];
  assign sda_lvl   = sda_sync[TOP];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // data edge while the clock stays high marks a bus condition
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/pex_link_fsm.sv
module pex_link_fsm
  import pex_pkg::*;
#(
  parameter int NUM_HALVES = 2,
  parameter int HIDX_W     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_pull,
  output logic [HIDX_W-1:0] cur_half,
  output logic [HIDX_W-1:0] evt_half,
  output logic              wr_evt,
  output logic              rd_evt,
  output logic [BYTE_W-1:0] wr_data
);
  link_state_t          state;
  logic [BYTE_W-1:0]    sreg;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic                 rw;
  logic                 ack_phase;
  logic                 mst_ack;
  logic [HIDX_W-1:0]    half;
  logic [HIDX_W-1:0]    next_half;

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = '1;

  assign next_half = (half == HIDX_W'(NUM_HALVES - 1)) ? '0 : half + 1'b1;
  assign cur_half  = half;
  assign wr_data   = sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sreg      <= '0;
      bit_cnt   <= '0;
      rw        <= 1'b0;
      ack_phase <= 1'b0;
      mst_ack   <= 1'b0;
      half      <= '0;
      sda_pull  <= 1'b0;
      wr_evt    <= 1'b0;
      rd_evt    <= 1'b0;
      evt_half  <= '0;
    end else begin
      wr_evt <= 1'b0;
      rd_evt <= 1'b0;
      if (start_evt) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        half      <= '0;
        ack_phase <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        ack_phase <= 1'b0;
        sda_pull  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            sreg    <= {sreg[BYTE_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (sreg[6:0] == dev_addr) begin
                rw        <= sda_lvl;
                ack_phase <= 1'b0;
                state     <= ST_ACK_A;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: if (scl_fall) begin
            if (!ack_phase) begin
              sda_pull  <= 1'b1;
              ack_phase <= 1'b1;
            end else begin
              ack_phase <= 1'b0;
              bit_cnt   <= '0;
              if (rw) begin
                sreg     <= rd_byte;
                sda_pull <= ~rd_byte[BYTE_W-1];
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            sreg    <= {sreg[BYTE_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              ack_phase <= 1'b0;
              state     <= ST_ACK_W;
            end
          end
          ST_ACK_W: if (scl_fall) begin
            if (!ack_phase) begin
              sda_pull  <= 1'b1;
              ack_phase <= 1'b1;
              wr_evt    <= 1'b1;
              evt_half  <= half;
              half      <= next_half;
            end else begin
              ack_phase <= 1'b0;
              sda_pull  <= 1'b0;
              bit_cnt   <= '0;
              state     <= ST_WR;
            end
          end
          ST_RD: if (scl_fall) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              sda_pull <= 1'b0;
              rd_evt   <= 1'b1;
              evt_half <= half;
              half     <= next_half;
              state    <= ST_ACK_R;
            end else begin
              sreg     <= {sreg[BYTE_W-2:0], 1'b0};
              sda_pull <= ~sreg[BYTE_W-2];
            end
          end
          ST_ACK_R: begin
            if (scl_rise) mst_ack <= ~sda_lvl;
            if (scl_fall) begin
              if (mst_ack) begin
                sreg     <= rd_byte;
                sda_pull <= ~rd_byte[BYTE_W-1];
                bit_cnt  <= '0;
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pex_port_bank.sv
module pex_port_bank
  import pex_pkg::*;
#(
  parameter int                       NUM_HALVES = 2,
  parameter int                       HIDX_W     = 1,
  parameter logic [NUM_HALVES*BYTE_W-1:0] OUT_RESET = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_evt,
  input  logic                         rd_evt,
  input  logic [HIDX_W-1:0]            evt_half,
  input  logic [HIDX_W-1:0]            cur_half,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [NUM_HALVES*BYTE_W-1:0] port_in,
  output logic [NUM_HALVES*BYTE_W-1:0] port_out,
  output logic [BYTE_W-1:0]            rd_byte,
  output logic [NUM_HALVES-1:0]        rd_strobe,
  output logic [NUM_HALVES-1:0]        wr_strobe
);
  assign rd_byte = port_in[cur_half*BYTE_W +: BYTE_W];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [BYTE_W-1:0] lat_q;
    logic              wr_q;
    logic              rd_q;
    logic              hit;

    assign hit = (evt_half == HIDX_W'(h));

    always_ff @(posedge clk) begin
      if (rst) begin
        lat_q <= OUT_RESET[h*BYTE_W +: BYTE_W];
        wr_q  <= 1'b0;
        rd_q  <= 1'b0;
      end else begin
        wr_q <= wr_evt & hit;
        rd_q <= rd_evt & hit;
        if (wr_evt && hit) lat_q <= wr_data;
      end
    end

    assign port_out[h*BYTE_W +: BYTE_W] = lat_q;
    assign wr_strobe[h] = wr_q;
    assign rd_strobe[h] = rd_q;
  end
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import pex_pkg::*;
#(
  parameter int          NUM_HALVES  = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  ADDR_PREFIX = 4'b0100,
  parameter logic [NUM_HALVES*8-1:0] OUT_RESET = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_pull_o,
  input  logic [2:0]              strap_i,
  input  logic [NUM_HALVES*8-1:0] port_in_i,
  output logic [NUM_HALVES*8-1:0] port_out_o,
  output logic [NUM_HALVES-1:0]   rd_strobe_o,
  output logic [NUM_HALVES-1:0]   wr_strobe_o
);
  localparam int PORT_W = NUM_HALVES * BYTE_W;
  localparam int HIDX_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;

  logic              scl_rise;
  logic              scl_fall;
  logic              sda_lvl;
  logic              start_evt;
  logic              stop_evt;
  logic [HIDX_W-1:0] cur_half;
  logic [HIDX_W-1:0] evt_half;
  logic              wr_evt;
  logic              rd_evt;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_byte;
  logic [6:0]        dev_addr;

  assign dev_addr = {ADDR_PREFIX, strap_i};

  pex_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  pex_link_fsm #(.NUM_HALVES(NUM_HALVES), .HIDX_W(HIDX_W)) u_link (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .dev_addr  (dev_addr),
    .rd_byte   (rd_byte),
    .sda_pull  (sda_pull_o),
    .cur_half  (cur_half),
    .evt_half  (evt_half),
    .wr_evt    (wr_evt),
    .rd_evt    (rd_evt),
    .wr_data   (wr_data)
  );

  pex_port_bank #(
    .NUM_HALVES (NUM_HALVES),
    .HIDX_W     (HIDX_W),
    .OUT_RESET  (PORT_W'(OUT_RESET))
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_evt    (wr_evt),
    .rd_evt    (rd_evt),
    .evt_half  (evt_half),
    .cur_half  (cur_half),
    .wr_data   (wr_data),
    .port_in   (port_in_i),
    .port_out  (port_out_o),
    .rd_byte   (rd_byte),
    .rd_strobe (rd_strobe_o),
    .wr_strobe (wr_strobe_o)
  );
endmodule

// File: rtl/pex_checker.sv
module pex_checker #(
  parameter int PORT_W = 16,
  parameter int NH     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_fall,
  input logic              stop_evt,
  input logic              sda_pull_o,
  input logic [PORT_W-1:0] port_out_o,
  input logic [NH-1:0]     rd_strobe_o,
  input logic [NH-1:0]     wr_strobe_o
);
  assert_pull_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> $past(scl_fall));

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_pull_o);

  assert_out_needs_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_out_o) |-> (wr_strobe_o != '0));

  assert_wr_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_strobe_o));

  assert_rd_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_strobe_o));

  assert_rd_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_o != '0) |=> (rd_strobe_o == '0));

  assert_wr_single_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe_o != '0) |=> (wr_strobe_o == '0));
endmodule

bind i2c_port_expander pex_checker #(
  .PORT_W (NUM_HALVES * 8),
  .NH     (NUM_HALVES)
) u_pex_checker (
  .clk         (clk),
  .rst         (rst),
  .scl_fall    (scl_fall),
  .stop_evt    (stop_evt),
  .sda_pull_o  (sda_pull_o),
  .port_out_o  (port_out_o),
  .rd_strobe_o (rd_strobe_o),
  .wr_strobe_o (wr_strobe_o)
);

// File: tb/test_i2c_port_expander.sv
module test_i2c_port_expander;
  localparam int         HP      = 10;
  localparam logic [2:0] STRAP   = 3'b101;
  localparam logic [6:0] MY_ADDR = {4'b0100, STRAP};
  localparam int         NVEC    = 5;
  // {addr[6:0], byte0, byte1, port_in[15:0], expect_ack}
  localparam logic [39:0] VECS [NVEC] = '{
    {MY_ADDR, 8'hA5, 8'h3C, 16'h1234, 1'b1},
    {MY_ADDR, 8'h00, 8'hFF, 16'h8001, 1'b1},
    {7'h24,   8'h11, 8'h22, 16'hBEEF, 1'b0},
    {7'h65,   8'h33, 8'h44, 16'h0F0F, 1'b0},
    {MY_ADDR, 8'h5A, 8'hC3, 16'hF00D, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic        sda_pull;
  logic [15:0] port_in = 16'h0000;
  logic [15:0] port_out;
  logic [1:0]  rd_strobe;
  logic [1:0]  wr_strobe;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_port_expander i_i2c_port_expander (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .strap_i     (STRAP),
    .port_in_i   (port_in),
    .port_out_o  (port_out),
    .rd_strobe_o (rd_strobe),
    .wr_strobe_o (wr_strobe)
  );

  int checks = 0;
  int errors = 0;
  int rd_cnt0 = 0, rd_cnt1 = 0, wr_cnt0 = 0, wr_cnt1 = 0;
  int exp_rd0 = 0, exp_rd1 = 0, exp_wr0 = 0, exp_wr1 = 0;
  int viol_r8 = 0, multi_hot = 0;
  logic pull_prev = 1'b0;
  logic done = 1'b0;
  int mid_swap_bit = -1;
  logic [15:0] mid_swap_val = 16'h0;
  logic [7:0]  rbuf [4];
  logic [15:0] exp_out = 16'hFFFF;

  always @(posedge clk) begin
    if (!rst) begin
      if (rd_strobe[0]) rd_cnt0++;
      if (rd_strobe[1]) rd_cnt1++;
      if (wr_strobe[0]) wr_cnt0++;
      if (wr_strobe[1]) wr_cnt1++;
      if ((rd_strobe[0] && rd_strobe[1]) || (wr_strobe[0] && wr_strobe[1])) multi_hot++;
      if (scl_m && (sda_pull !== pull_prev)) viol_r8++;
    end
    pull_prev <= sda_pull;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_hp();
    scl_m = 1'b1; wait_hp();
    sda_m = 1'b0; wait_hp();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_hp();
    scl_m = 1'b1; wait_hp();
    sda_m = 1'b1; wait_hp();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_hp();
    scl_m = 1'b1; wait_hp();
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_hp();
    scl_m = 1'b1;
    repeat (HP/2) @(negedge clk);
    b = sda_line;
    repeat (HP/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic bt;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(bt);
    ack = ~bt;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic bt;
    for (int i = 7; i >= 0; i--) begin
      get_bit(bt);
      d[i] = bt;
      if (i == mid_swap_bit) port_in = mid_swap_val;
    end
    put_bit(~give_ack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          output logic aack);
    logic k;
    bus_start();
    send_byte({a, 1'b0}, aack);
    send_byte(d0, k);
    send_byte(d1, k);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, input int n, output logic aack);
    logic [7:0] b;
    bus_start();
    send_byte({a, 1'b1}, aack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      rbuf[i] = b;
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic aack, k, bt;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 port_out in reset", port_out, 16'hFFFF);
    check("R10 pull in reset", sda_pull, 1'b0);
    check("R10 strobes in reset", {rd_strobe, wr_strobe}, 4'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 port_out after reset", port_out, 16'hFFFF);

    // table walk: write two bytes, read two bytes
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0]  va;
      logic [7:0]  w0, w1;
      logic [15:0] pin;
      logic        ex;
      {va, w0, w1, pin, ex} = VECS[v];
      do_write(va, w0, w1, aack);
      check(ex ? "R2 write address ack" : "R3 write address nack", aack, ex);
      if (ex) begin
        exp_out = {w1, w0};
        exp_wr0++; exp_wr1++;
      end
      check(ex ? "R4 port_out after write" : "R3 port_out unchanged", port_out, exp_out);
      port_in = pin;
      do_read(va, 2, aack);
      bus_stop();
      check(ex ? "R2 read address ack" : "R3 read address nack", aack, ex);
      if (ex) begin
        exp_rd0++; exp_rd1++;
        check("R5 read low half", rbuf[0], pin[7:0]);
        check("R5 read high half", rbuf[1], pin[15:8]);
      end else begin
        check("R3 bus released byte0", rbuf[0], 8'hFF);
        check("R3 bus released byte1", rbuf[1], 8'hFF);
      end
    end
    check("R12 write strobes low half", wr_cnt0, exp_wr0);
    check("R12 write strobes high half", wr_cnt1, exp_wr1);

    // R5/R6/R7: long read, alternating halves, NACK ends it
    port_in = 16'hA1B2;
    do_read(MY_ADDR, 4, aack);
    check("R6 long read address ack", aack, 1'b1);
    check("R6 byte0", rbuf[0], 8'hB2);
    check("R6 byte1", rbuf[1], 8'hA1);
    check("R6 byte2", rbuf[2], 8'hB2);
    check("R6 byte3", rbuf[3], 8'hA1);
    get_bit(bt);
    check("R6 released after nack", bt, 1'b1);
    bus_stop();
    exp_rd0 += 2; exp_rd1 += 2;
    check("R7 read strobes low half", rd_cnt0, exp_rd0);
    check("R7 read strobes high half", rd_cnt1, exp_rd1);

    // R5: input captured at the start of the byte
    port_in = 16'h00C3;
    mid_swap_val = 16'h003C;
    mid_swap_bit = 4;
    do_read(MY_ADDR, 1, aack);
    bus_stop();
    mid_swap_bit = -1;
    exp_rd0++;
    check("R5 capture at byte start", rbuf[0], 8'hC3);

    // R9: repeated START mid-address, then a three-byte write (R4 wrap)
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, aack);
    check("R9 ack after repeated start", aack, 1'b1);
    send_byte(8'h77, k);
    send_byte(8'h88, k);
    send_byte(8'h99, k);
    bus_stop();
    exp_out = {8'h88, 8'h99};
    exp_wr0 += 2; exp_wr1++;
    check("R4 third byte wraps to low half", port_out, exp_out);

    // R11: STOP in the middle of a data byte
    bus_start();
    send_byte({MY_ADDR, 1'b0}, aack);
    send_byte(8'h96, k);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    exp_out = {8'h88, 8'h96};
    exp_wr0++;
    check("R11 partial byte discarded", port_out, exp_out);

    // R1: bytes without START are ignored
    send_byte({MY_ADDR, 1'b0}, aack);
    check("R1 no ack without start", aack, 1'b0);
    send_byte(8'h12, k);
    bus_stop();
    check("R1 port_out unchanged without start", port_out, exp_out);
    check("R1 pull released when idle", sda_pull, 1'b0);

    repeat (4) @(negedge clk);
    check("R12 total write strobes low", wr_cnt0, exp_wr0);
    check("R12 total write strobes high", wr_cnt1, exp_wr1);
    check("R7 total read strobes low", rd_cnt0, exp_rd0);
    check("R7 total read strobes high", rd_cnt1, exp_rd1);
    check("R12 strobes never multi-hot", multi_hot, 0);
    check("R8 pull steady while clock high", viol_r8, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule